// File: doc/BRIEF.md
# Stack Push/Pull Sequencer

This block carries out the four single-byte stack transfers of an 8-bit processor core: saving the accumulator, saving the status byte, and restoring either of them. The stack occupies one fixed 256-byte page of memory, so every stack access goes to the page base combined with an 8-bit stack pointer that the block owns. A push stores at the slot the pointer names and then moves the pointer down. A pull first moves the pointer up and then reads from the slot it now names. Both directions wrap around within the page.

The core issues a request with an operation code. The block drives the memory address, write data and write strobe itself, and holds `busy` until the transfer ends. The memory is synchronous: read data appears one cycle after the address. When a pull finishes, the block returns the fetched byte with a one-cycle load strobe for the destination register. A restored accumulator also updates the zero and negative flags. A restored status byte leaves those flags alone and never alters the pointer beyond its increment.

Top module: `stack_unit`

## Requirements
- R1: After synchronous reset the stack pointer is 0xFF, and `busy`, `done`, `mem_we`, `acc_load`, `stat_load`, `flag_z` and `flag_n` are all 0.
- R2: `mem_addr` always equals 0x01 in its upper byte and the stack pointer in its lower byte.
- R3: Only four codes start a transfer: 0x48 pushes the accumulator, 0x08 pushes the status byte, 0x68 pulls into the accumulator, and 0x28 pulls into the status register. Any other code leaves `busy`, `mem_we` and the pointer unchanged.
- R4: A push lasts two cycles after acceptance. In the first cycle the address is presented with `mem_we` low. In the second cycle `mem_we` is high, and `mem_wdata` carries the byte sampled at acceptance, at the address of the pointer's old value. The pointer then drops by one, and `done` pulses in the cycle after.
- R5: A push with the pointer at 0x00 leaves it at 0xFF.
- R6: A pull lasts three cycles after acceptance. The pointer rises by one in the first cycle. The memory is read at the new address. In the cycle after the third, `done` pulses and `pull_data` holds the byte stored there.
- R7: A pull with the pointer at 0xFF leaves it at 0x00.
- R8: A pull into the accumulator pulses `acc_load` with `done`. At that point `flag_z` is 1 exactly when the byte is zero, and `flag_n` equals the byte's bit 7.
- R9: A pull into the status register pulses `stat_load` with `done`. It leaves `flag_z` and `flag_n` unchanged, and the pointer is only incremented, never loaded from the data.
- R10: `busy` is high from the cycle after acceptance until the transfer's last cycle. Requests that arrive while `busy` is high are dropped.
- R11: `mem_we` is high for exactly one cycle per push and never during a pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request strobe |
| req_op | input | 8 | Operation code of the request |
| acc_in | input | 8 | Accumulator value to be pushed |
| status_in | input | 8 | Status value to be pushed |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after a transfer ends |
| mem_addr | output | 16 | Stack memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| sp | output | 8 | Current stack pointer |
| pull_data | output | 8 | Byte returned by the latest pull |
| acc_load | output | 1 | Load strobe for the accumulator |
| stat_load | output | 1 | Load strobe for the status register |
| flag_z | output | 1 | Zero flag from the latest accumulator pull |
| flag_n | output | 1 | Negative flag from the latest accumulator pull |

## Verification
Two events can land in the same cycle: a fresh request, and the cycle in which an earlier transfer still holds `busy`. The bench raises a pull request in the first busy cycle of a push. It then confirms that the push completes with its own data and pointer step, and that no pull follows. A second collision is a push at pointer 0x00 that wraps to 0xFF, followed by a pull that must wrap back. The bench judges both through the pointer, the write strobe and the bytes read back later.

// File: rtl/stk_pkg.sv
package stk_pkg;
    parameter int DATA_W = 8;
    parameter int PTR_W  = 8;
    parameter int PAGE_W = 8;

    localparam logic [7:0] OPC_PUSH_ACC  = 8'h48;
    localparam logic [7:0] OPC_PULL_ACC  = 8'h68;
    localparam logic [7:0] OPC_PUSH_STAT = 8'h08;
    localparam logic [7:0] OPC_PULL_STAT = 8'h28;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_ADDR,
        ST_PUSH_WR,
        ST_PULL_INC,
        ST_PULL_RD,
        ST_PULL_LD
    } stk_state_e;

    typedef struct packed {
        logic valid;
        logic pull;
        logic status;
    } stk_cmd_t;

    function automatic stk_cmd_t decode_op(input logic [7:0] op);
        stk_cmd_t c;
        c = '0;
        case (op)
            OPC_PUSH_ACC:  c = '{valid: 1'b1, pull: 1'b0, status: 1'b0};
            OPC_PULL_ACC:  c = '{valid: 1'b1, pull: 1'b1, status: 1'b0};
            OPC_PUSH_STAT: c = '{valid: 1'b1, pull: 1'b0, status: 1'b1};
            OPC_PULL_STAT: c = '{valid: 1'b1, pull: 1'b1, status: 1'b1};
            default:       c = '0;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int PTR_W = stk_pkg::PTR_W,
    parameter logic [PTR_W-1:0] SP_INIT = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [PTR_W-1:0] sp
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            sp <= SP_INIT;
        else if (inc)
            sp <= sp + ONE;
        else if (dec)
            sp <= sp - ONE;
    end

    // R5
    dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc) |=> (sp == $past(sp) - ONE));

    // R7
    inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        inc |=> (sp == $past(sp) + ONE));

    // R3
    sp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc && !dec) |=> $stable(sp));
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [7:0]    req_op,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] status_in,
    output stk_state_e    state,
    output logic          to_status,
    output logic [DW-1:0] push_data,
    output logic          done
);
    stk_state_e nxt;
    stk_cmd_t   cmd;
    logic       accept;

    always_comb begin
        cmd    = decode_op(req_op);
        accept = (state == ST_IDLE) && req_valid && cmd.valid;
        nxt    = state;
        unique case (state)
            ST_IDLE:      if (accept) nxt = cmd.pull ? ST_PULL_INC : ST_PUSH_ADDR;
            ST_PUSH_ADDR: nxt = ST_PUSH_WR;
            ST_PUSH_WR:   nxt = ST_IDLE;
            ST_PULL_INC:  nxt = ST_PULL_RD;
            ST_PULL_RD:   nxt = ST_PULL_LD;
            ST_PULL_LD:   nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            to_status <= 1'b0;
            push_data <= '0;
            done      <= 1'b0;
        end else begin
            state <= nxt;
            done  <= (state == ST_PUSH_WR) || (state == ST_PULL_LD);
            if (accept) begin
                to_status <= cmd.status;
                push_data <= cmd.status ? status_in : acc_in;
            end
        end
    end

    // R4
    push_len_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PUSH_ADDR) |=> (state == ST_PUSH_WR));

    // R6
    pull_len_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PULL_INC) |=> (state == ST_PULL_RD) ##1 (state == ST_PULL_LD));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> ($stable(to_status) && $stable(push_data)));
endmodule

// File: rtl/stk_result.sv
module stk_result #(
    parameter int DW = stk_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          to_status,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] pull_data,
    output logic          acc_load,
    output logic          stat_load,
    output logic          flag_z,
    output logic          flag_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pull_data <= '0;
            acc_load  <= 1'b0;
            stat_load <= 1'b0;
            flag_z    <= 1'b0;
            flag_n    <= 1'b0;
        end else begin
            acc_load  <= capture && !to_status;
            stat_load <= capture && to_status;
            if (capture) begin
                pull_data <= rdata;
                if (!to_status) begin
                    flag_z <= (rdata == '0);
                    flag_n <= rdata[DW-1];
                end
            end
        end
    end

    // R8
    acc_flags_chk: assert property (@(posedge clk) disable iff (rst)
        acc_load |-> ((flag_z == (pull_data == '0)) && (flag_n == pull_data[DW-1])));

    // R9
    stat_keep_chk: assert property (@(posedge clk) disable iff (rst)
        stat_load |-> ($stable(flag_z) && $stable(flag_n)));

    // R8
    one_load_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_load && stat_load));
endmodule

// File: rtl/stack_unit.sv
module stack_unit
    import stk_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = PTR_W,
    parameter int GW = PAGE_W,
    parameter logic [GW-1:0] PAGE = GW'(1),
    parameter logic [PW-1:0] SP_INIT = '1,
    localparam int AW = GW + PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [7:0]    req_op,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] status_in,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic [PW-1:0] sp,
    output logic [DW-1:0] pull_data,
    output logic          acc_load,
    output logic          stat_load,
    output logic          flag_z,
    output logic          flag_n
);
    stk_state_e state;
    logic       to_status;
    logic       sp_inc;
    logic       sp_dec;

    stk_seq #(.DW(DW)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .acc_in    (acc_in),
        .status_in (status_in),
        .state     (state),
        .to_status (to_status),
        .push_data (mem_wdata),
        .done      (done)
    );

    assign sp_inc = (state == ST_PULL_INC);
    assign sp_dec = (state == ST_PUSH_WR);

    stk_ptr #(.PTR_W(PW), .SP_INIT(SP_INIT)) ptr_i (
        .clk (clk),
        .rst (rst),
        .inc (sp_inc),
        .dec (sp_dec),
        .sp  (sp)
    );

    stk_result #(.DW(DW)) res_i (
        .clk       (clk),
        .rst       (rst),
        .capture   (state == ST_PULL_LD),
        .to_status (to_status),
        .rdata     (mem_rdata),
        .pull_data (pull_data),
        .acc_load  (acc_load),
        .stat_load (stat_load),
        .flag_z    (flag_z),
        .flag_n    (flag_n)
    );

    assign busy     = (state != ST_IDLE);
    assign mem_we   = (state == ST_PUSH_WR);
    assign mem_addr = {PAGE, sp};

    // R11
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R2
    addr_page_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (mem_addr[AW-1:PW] == PAGE));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !$past(done)));
endmodule

// File: tb/stack_unit_tb.sv
`timescale 1ns/1ps
module stack_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [7:0]  req_op;
    logic [7:0]  acc_in;
    logic [7:0]  status_in;
    logic [7:0]  mem_rdata;
    logic        busy;
    logic        done;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  sp;
    logic [7:0]  pull_data;
    logic        acc_load;
    logic        stat_load;
    logic        flag_z;
    logic        flag_n;

    int checks = 0;
    int fails  = 0;
    logic [7:0] ram [256];

    always #2 clk = ~clk;

    stack_unit dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .acc_in(acc_in), .status_in(status_in), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .sp(sp), .pull_data(pull_data),
        .acc_load(acc_load), .stat_load(stat_load), .flag_z(flag_z), .flag_n(flag_n)
    );

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= ram[mem_addr[7:0]];
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] op, input logic [7:0] a, input logic [7:0] s);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; acc_in = a; status_in = s;
        @(negedge clk);
        req_valid = 1'b0; req_op = 8'h00;
    endtask

    task automatic t_reset();
        chk("R1 sp", sp, 8'hFF);
        chk("R1 busy", busy, 0);
        chk("R1 we", mem_we, 0);
        chk("R1 done", done, 0);
        chk("R1 loads", {acc_load, stat_load}, 0);
        chk("R1 flags", {flag_z, flag_n}, 0);
    endtask

    task automatic t_push(input logic [7:0] op, input logic [7:0] a, input logic [7:0] s,
                          input string rq);
        logic [7:0] sp0;
        logic [7:0] d;
        sp0 = sp;
        d = (op == 8'h08) ? s : a;
        issue(op, a, s);
        chk("R10 busy push", busy, 1);
        chk("R4 we low first cycle", mem_we, 0);
        chk("R2 addr", mem_addr, {8'h01, sp0});
        @(negedge clk);
        chk("R4 we high", mem_we, 1);
        chk("R4 wdata", mem_wdata, d);
        chk("R2 addr write", mem_addr, {8'h01, sp0});
        @(negedge clk);
        chk(rq, sp, 8'(sp0 - 8'd1));
        chk("R4 done", done, 1);
        chk("R10 busy end", busy, 0);
        chk("R11 we single", mem_we, 0);
    endtask

    task automatic t_pull(input logic [7:0] op, input logic [7:0] exp_d, input string rq);
        logic [7:0] sp0;
        logic       z0;
        logic       n0;
        sp0 = sp; z0 = flag_z; n0 = flag_n;
        issue(op, 8'h00, 8'h00);
        chk("R10 busy pull", busy, 1);
        @(negedge clk);
        chk(rq, sp, 8'(sp0 + 8'd1));
        chk("R2 addr pull", mem_addr, {8'h01, 8'(sp0 + 8'd1)});
        chk("R11 no we pull", mem_we, 0);
        @(negedge clk);
        chk("R6 busy third", busy, 1);
        @(negedge clk);
        chk("R6 done", done, 1);
        chk("R6 data", pull_data, exp_d);
        chk("R9 sp not loaded", sp, 8'(sp0 + 8'd1));
        if (op == 8'h68) begin
            chk("R8 acc_load", {acc_load, stat_load}, 2'b10);
            chk("R8 zero", flag_z, exp_d == 8'h00);
            chk("R8 neg", flag_n, exp_d[7]);
        end else begin
            chk("R9 stat_load", {acc_load, stat_load}, 2'b01);
            chk("R9 flags kept", {flag_z, flag_n}, {z0, n0});
        end
    endtask

    task automatic t_bad_op();
        logic [7:0] sp0;
        sp0 = sp;
        issue(8'h4C, 8'h33, 8'h44);
        chk("R3 no busy", busy, 0);
        @(negedge clk);
        chk("R3 no we", mem_we, 0);
        chk("R3 sp kept", sp, sp0);
    endtask

    task automatic t_busy_drop();
        logic [7:0] sp0;
        sp0 = sp;
        issue(8'h48, 8'h11, 8'h00);
        req_valid = 1'b1; req_op = 8'h68;
        @(negedge clk);
        req_valid = 1'b0; req_op = 8'h00;
        chk("R10 push write still", mem_we, 1);
        @(negedge clk);
        chk("R10 sp after push", sp, 8'(sp0 - 8'd1));
        @(negedge clk);
        chk("R10 dropped pull busy", busy, 0);
        chk("R10 dropped pull sp", sp, 8'(sp0 - 8'd1));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = 8'h00;
        rst = 1'b1; req_valid = 1'b0; req_op = 8'h00; acc_in = 8'h00; status_in = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_push(8'h48, 8'h5A, 8'h00, "R4 push acc");
        t_push(8'h08, 8'h00, 8'h80, "R4 push status");
        t_pull(8'h28, 8'h80, "R6 pull status");
        t_pull(8'h68, 8'h5A, "R6 pull acc");
        t_pull(8'h68, 8'h00, "R7 pull wrap");
        t_push(8'h48, 8'h9C, 8'h00, "R5 push wrap");
        t_pull(8'h68, 8'h9C, "R7 pull wrap again");
        t_push(8'h08, 8'h00, 8'h00, "R4 push zero status");
        t_pull(8'h28, 8'h00, "R9 pull zero status");
        t_bad_op();
        t_busy_drop();
        t_pull(8'h68, 8'h11, "R10 pull after drop");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule